// File: doc/BRIEF.md
# Video Sync Pulse Classifier

This block sits behind two analog comparators that watch a composite video signal. One comparator output falls during horizontal sync pulses, the other (a separate, lower threshold) falls only during the long vertical sync interval. Both arrive active low. The block counts, in system clock cycles, how long each input has stayed low. When the count reaches a parameterised width, it emits a one-cycle strobe: a line strobe for the horizontal input and a frame strobe for the vertical input.

A vertical interval has a train of repeated low pulses. After a frame strobe, a holdoff window masks the comparator results. The controller then needs one line strobe before it accepts another frame strobe, so each field yields exactly one frame strobe. A 9-bit line counter counts accepted line strobes within a frame. It clears on each frame strobe and stops at its maximum value. Downstream logic uses the line number and the strobes to locate features within the picture.

Top module: `sync_classifier`

## Requirements
- R1: A line strobe `hsync_o` is high for one cycle when `hsync_ni` has been sampled low on `H_LOW_CYC` consecutive clock edges. It appears in the cycle after edge number `H_LOW_CYC + 1`, counting from the first low sample, so the first low sample is edge 1.
- R2: A low pulse on `hsync_ni` shorter than `H_LOW_CYC` samples produces no strobe. Any high sample restarts the count from zero.
- R3: One low pulse produces at most one strobe, however long it lasts.
- R4: A frame strobe `vsync_o` follows the same width rule on `vsync_ni` with `V_LOW_CYC`. Shorter vertical pulses produce no strobe.
- R5: After the edge that raises `vsync_o`, the controller ignores width detections on both inputs at the next `HOLDOFF_CYC + 1` edges.
- R6: After the holdoff, vertical detections are ignored until one horizontal detection has produced a line strobe. From that point, frame strobes are accepted again.
- R7: `line_o` increments by one on the same edge that raises `hsync_o`. It changes on no other edge except as R8 and R11 state.
- R8: `line_o` reads 0 in the cycle that `vsync_o` is high.
- R9: `line_o` saturates at 511 (all ones, 9 bits) and does not wrap.
- R10: If both detections fall on the same edge while the controller is monitoring, only the frame strobe is issued and `line_o` is cleared. The two strobes are never high together.
- R11: `rst_ni` low clears both strobes and `line_o` to 0 and returns the controller to monitoring. In that state a line strobe needs no prior frame strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (25.175 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_ni | input | 1 | Horizontal sync comparator output, low during sync |
| vsync_ni | input | 1 | Vertical sync comparator output, low during sync |
| hsync_o | output | 1 | One-cycle line strobe |
| vsync_o | output | 1 | One-cycle frame strobe |
| line_o | output | LINE_W | Accepted line strobes since the last frame strobe, saturating |

## Verification
The edges of the holdoff window are the hardest situation to reach from the ports. The window is measured from an internal edge, and it acts only on width detections that land several cycles after a pulse starts. The bench timestamps the edge that raised the frame strobe. It then starts a horizontal pulse so that its detection falls exactly on the last masked edge in one frame, and exactly on the first open edge in the next. The same arithmetic aligns a vertical and a horizontal detection onto one edge to exercise the priority rule.

// File: rtl/sync_cls_pkg.sv
package sync_cls_pkg;
  typedef enum logic [1:0] {
    ST_MON   = 2'd0,  // both detectors live
    ST_HOLD  = 2'd1,  // masking after frame strobe
    ST_WAITH = 2'd2   // frame strobe locked until a line strobe
  } ctl_state_e;
endpackage

// File: rtl/sync_low_timer.sv
module sync_low_timer #(
  parameter int unsigned THR = 81
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_ni,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(THR + 1);

  logic [CW-1:0] cnt_q;
  logic          hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= !low_ni && (cnt_q == CW'(THR - 1));
      if (low_ni)                 cnt_q <= '0;
      else if (cnt_q != CW'(THR)) cnt_q <= cnt_q + 1'b1;  // park at THR: one hit per pulse
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/sync_holdoff.sv
module sync_holdoff #(
  parameter int unsigned HOLD = 9139
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= HW'(HOLD);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sync_line_cnt.sv
module sync_line_cnt #(
  parameter int unsigned LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [LINE_W-1:0] line_o
);
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    line_q <= '0;
    else if (clr_i)                 line_q <= '0;
    else if (inc_i && line_q != '1) line_q <= line_q + 1'b1;
  end

  assign line_o = line_q;
endmodule

// File: rtl/sync_classifier.sv
module sync_classifier
  import sync_cls_pkg::*;
#(
  parameter int unsigned H_LOW_CYC   = 81,
  parameter int unsigned V_LOW_CYC   = 25175,
  parameter int unsigned HOLDOFF_CYC = 9139,
  parameter int unsigned LINE_W      = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_ni,
  input  logic              vsync_ni,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [LINE_W-1:0] line_o
);
  logic h_hit, v_hit, hold_busy;
  logic h_take, v_take;
  logic hs_q, vs_q;
  ctl_state_e st_q, st_d;

  sync_low_timer #(.THR(H_LOW_CYC)) u_h_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .low_ni(hsync_ni), .hit_o(h_hit)
  );

  sync_low_timer #(.THR(V_LOW_CYC)) u_v_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .low_ni(vsync_ni), .hit_o(v_hit)
  );

  sync_holdoff #(.HOLD(HOLDOFF_CYC)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(v_take), .busy_o(hold_busy)
  );

  sync_line_cnt #(.LINE_W(LINE_W)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(v_take), .inc_i(h_take), .line_o(line_o)
  );

  always_comb begin
    st_d   = st_q;
    v_take = 1'b0;
    h_take = 1'b0;
    unique case (st_q)
      ST_MON: begin
        if (v_hit) begin
          v_take = 1'b1;       // vertical wins a tie
          st_d   = ST_HOLD;
        end else begin
          h_take = h_hit;
        end
      end
      ST_HOLD: begin
        if (!hold_busy) st_d = ST_WAITH;
      end
      ST_WAITH: begin
        if (h_hit) begin
          h_take = 1'b1;
          st_d   = ST_MON;
        end
      end
      default: st_d = ST_MON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_MON;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      st_q <= st_d;
      hs_q <= h_take;
      vs_q <= v_take;
    end
  end

  assign hsync_o = hs_q;
  assign vsync_o = vs_q;
endmodule

// File: rtl/sync_classifier_chk.sv
module sync_classifier_chk #(
  parameter int unsigned LINE_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic [LINE_W-1:0] line_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b1;
    else if (vsync_o) armed_q <= 1'b0;
    else if (hsync_o) armed_q <= 1'b1;
  end

  assert_h_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |=> !hsync_o);

  assert_v_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |=> !vsync_o);

  assert_frame_needs_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> armed_q);

  assert_line_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_o && $past(line_o) != '1) |-> line_o == $past(line_o) + 1'b1);

  assert_line_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> (hsync_o || vsync_o));

  assert_frame_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> line_o == '0);

  assert_line_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(line_o) == '1 && !vsync_o) |-> line_o == '1);

  assert_no_overlap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hsync_o && vsync_o));
endmodule

bind sync_classifier sync_classifier_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_o(hsync_o), .vsync_o(vsync_o), .line_o(line_o)
);

// File: tb/sync_classifier_test.sv
module sync_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int H   = 4;
  localparam int V   = 12;
  localparam int HLD = 40;
  localparam int LW  = 9;

  logic clk = 1'b0, rst_n = 1'b0, hs_n = 1'b1, vs_n = 1'b1;
  logic hs_o, vs_o;
  logic [LW-1:0] line;
  int cyc = 0, last_vs = 0;
  int checks = 0, errors = 0;
  int exp_line = 0;
  bit done = 1'b0;

  sync_classifier #(.H_LOW_CYC(H), .V_LOW_CYC(V), .HOLDOFF_CYC(HLD), .LINE_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_ni(hs_n), .vsync_ni(vs_n),
    .hsync_o(hs_o), .vsync_o(vs_o), .line_o(line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (vs_o) last_vs = cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one low pulse, sample each negedge; fi = first sample index with a strobe
  task automatic pulse(input bit v, input int len, input int tail,
                       output int fi, output int n_h, output int n_v);
    fi = 0; n_h = 0; n_v = 0;
    @(negedge clk);
    if (v) vs_n = 1'b0; else hs_n = 1'b0;
    for (int k = 1; k <= len + tail; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == len) begin hs_n = 1'b1; vs_n = 1'b1; end
      if ((hs_o || vs_o) && fi == 0) fi = k;
      n_h += int'(hs_o); n_v += int'(vs_o);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int fi, nh, nv, e0;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(hs_o == 0 && vs_o == 0, "R11 strobes in reset", int'(hs_o) + int'(vs_o), 0);
    chk(line == 0, "R11 line in reset", int'(line), 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R3 horizontal width sweep
    for (int len = 1; len <= H + 5; len++) begin
      pulse(0, len, 3, fi, nh, nv);
      if (len >= H) begin
        exp_line++;
        chk(nh == 1, "R3 one line strobe per pulse", nh, 1);
        chk(fi == H + 1, "R1 line strobe timing", fi, H + 1);
      end else begin
        chk(nh == 0, "R2 short line pulse", nh, 0);
      end
      chk(nv == 0, "R1 no frame strobe from hsync", nv, 0);
      chk(int'(line) == exp_line, "R7 line count", int'(line), exp_line);
    end

    // R4 vertical width sweep
    for (int len = V - 2; len < V; len++) begin
      pulse(1, len, 3, fi, nh, nv);
      chk(nv == 0, "R4 short frame pulse", nv, 0);
    end
    pulse(1, V + 3, 3, fi, nh, nv);
    chk(nv == 1 && fi == V + 1, "R4 frame strobe timing", fi, V + 1);
    chk(line == 0, "R8 line cleared by frame", int'(line), 0);
    e0 = last_vs;

    // R5 holdoff masks both inputs
    pulse(1, V + 2, 2, fi, nh, nv);
    chk(nv == 0, "R5 vertical masked in holdoff", nv, 0);
    pulse(0, H + 1, 2, fi, nh, nv);
    chk(nh == 0, "R5 horizontal masked in holdoff", nh, 0);
    chk(line == 0, "R5 line unchanged in holdoff", int'(line), 0);
    wait_to(e0 + HLD + 6);
    // R6 frame locked until a line strobe
    pulse(1, V + 2, 3, fi, nh, nv);
    chk(nv == 0, "R6 frame needs line first", nv, 0);
    pulse(0, H + 1, 3, fi, nh, nv);
    chk(nh == 1 && fi == H + 1, "R6 line accepted after holdoff", fi, H + 1);
    chk(line == 1, "R6 line counted", int'(line), 1);
    pulse(1, V, 3, fi, nh, nv);
    chk(nv == 1, "R6 frame accepted again", nv, 1);
    e0 = last_vs;

    // R5 last masked edge: detection at e0+HLD+1
    wait_to(e0 + HLD + 1 - H - 2);
    pulse(0, H + 1, 3, fi, nh, nv);
    chk(nh == 0, "R5 last holdoff edge masks", nh, 0);
    pulse(0, H + 1, 3, fi, nh, nv);
    pulse(1, V, 3, fi, nh, nv);
    chk(nv == 1, "R6 frame after line", nv, 1);
    e0 = last_vs;
    // R6 first open edge: detection at e0+HLD+2
    wait_to(e0 + HLD + 2 - H - 2);
    pulse(0, H + 1, 3, fi, nh, nv);
    chk(nh == 1 && fi == H + 1, "R6 first open edge accepts", nh, 1);
    chk(line == 1, "R7 line after open edge", int'(line), 1);

    // R10 simultaneous detections in monitoring state
    nh = 0; nv = 0;
    @(negedge clk); vs_n = 1'b0;
    for (int k = 1; k <= V + 4; k++) begin
      if (k == V - H + 1) hs_n = 1'b0;
      @(posedge clk); @(negedge clk);
      nh += int'(hs_o); nv += int'(vs_o);
    end
    hs_n = 1'b1; vs_n = 1'b1;
    chk(nv == 1, "R10 frame wins tie", nv, 1);
    chk(nh == 0, "R10 line dropped on tie", nh, 0);
    chk(line == 0, "R10 line cleared on tie", int'(line), 0);

    // R9 saturation
    idle(HLD + 5);
    for (int i = 1; i <= (1 << LW) + 3; i++) begin
      pulse(0, H, 2, fi, nh, nv);
      if (i == (1 << LW) - 1)
        chk(int'(line) == (1 << LW) - 1, "R9 reaches max", int'(line), (1 << LW) - 1);
    end
    chk(int'(line) == (1 << LW) - 1, "R9 holds at max", int'(line), (1 << LW) - 1);

    // R11 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(line == 0, "R11 reset clears line", int'(line), 0);
    rst_n = 1'b1;
    pulse(0, H + 1, 3, fi, nh, nv);
    chk(nh == 1 && line == 1, "R11 monitoring after reset", int'(line), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule